// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Unit

This block gives a host three 8-bit parallel ports, called A, B and C. Port C is handled as two 4-bit halves. The host uses a small register interface to program the unit and to move data. That interface has an active-low chip select, a 2-bit register address, separate active-low read and write strobes, an 8-bit write bus and an 8-bit read bus with a read-valid flag. Each port pin has three signals: an output value, an output-enable and a live input. A pin is driven only while its port group is set to output.

The control register has two meanings, chosen by bit 7 of the byte written to it. When bit 7 is 1, the byte is a configuration word. It sets the direction of port A, port B and each half of port C, and it also records mode fields. When bit 7 is 0, the byte is a single-bit command that sets or clears one bit of port C. Every mode field value is accepted, but the ports always act as plain latched outputs or plain pass-through inputs.

A small bus state machine has two states. BUS_IDLE waits for a write strobe. On the first clock edge where chip select and the write strobe are both low, it performs one register update and moves to BUS_HOLD. BUS_HOLD performs no updates and returns to BUS_IDLE once either the write strobe or chip select goes high. Reset puts the machine in BUS_IDLE.

Top module: `ppi_unit`

## Requirements
- R1: While reset is high and after it ends, the stored configuration word reads back as 0x00. All output-enables are 0, so every port is an input, and all output latches are 0.
- R2: Registers are selected by `addr` only while `cs_n` is 0: 0 is port A, 1 is port B, 2 is port C, 3 is the control register. A write with `cs_n` high changes nothing. A write to one port changes only that port's latch.
- R3: A configuration word sets the port directions as follows, where 1 means input and 0 means output: bit 4 sets port A, bit 3 sets port C bits 7:4, bit 1 sets port B and bit 0 sets port C bits 3:0. Each output-enable bit is 1 exactly when its group is set to output.
- R4: Writing a configuration word clears the A, B and C output latches to 0. A later read of the control register returns that word.
- R5: A control write with bit 7 = 0 is a bit command. Bits 3:1 choose the port C bit, and bit 0 gives the new value of that bit. All other port C bits, the directions and the stored configuration word are unchanged.
- R6: A port read returns the live pins for groups set to input and the output latch for groups set to output. For port C, each half is chosen separately.
- R7: A write commits once per strobe. If `din` changes while `wr_n` is held low, the register keeps the value from the first cycle of the strobe.
- R8: Non-zero mode fields (bits 6:5 and bit 2) do not change port behaviour. Directions still follow R3.
- R9: `dout_en` is 1 exactly while `cs_n` and `rd_n` are low and `wr_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 2 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_en | output | 1 | Read data valid |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output-enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output-enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C output-enables |

## Verification
The bench targets the following cases, each matched to the failure it would expose:
- A bit command whose bit-select field points at bit 7. A design that decoded it as a configuration word would reset all directions.
- Port C with one half set to input and the other to output. A design that applied a single direction to the whole port would return the wrong nibble on a read.
- A strobe held low while `din` changes. A design without the hold state would end up with the later value.
- Writes made with chip select high. A design that ignored chip select would alter a latch here.
- A configuration word written after latches were loaded. A design that skipped the clear would keep driving stale data.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    typedef enum logic [1:0] {
        SEL_PA = 2'b00,
        SEL_PB = 2'b01,
        SEL_PC = 2'b10,
        SEL_CW = 2'b11
    } sel_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_HOLD = 1'b1
    } bus_st_e;

    // direction per group, 1 = input
    typedef struct packed {
        logic a_in;
        logic cu_in;
        logic b_in;
        logic cl_in;
    } dir_t;

    localparam dir_t DIR_ALL_IN = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_bus_fsm.sv
module ppi_bus_fsm
    import ppi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    output logic commit
);
    bus_st_e st_q, st_d;
    logic    strobe;

    assign strobe = !cs_n && !wr_n;

    always_ff @(posedge clk) begin
        if (rst) st_q <= BUS_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        unique case (st_q)
            BUS_IDLE: begin
                if (strobe) begin
                    commit = 1'b1;
                    st_d   = BUS_HOLD;
                end
            end
            BUS_HOLD: begin
                if (!strobe) st_d = BUS_IDLE;
            end
            default: st_d = BUS_IDLE;
        endcase
    end
endmodule

// File: rtl/ppi_regs.sv
module ppi_regs
    import ppi_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  logic [1:0]    addr,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] lat_a,
    output logic [PW-1:0] lat_b,
    output logic [PW-1:0] lat_c,
    output dir_t          dir,
    output logic [PW-1:0] cword
);
    localparam int IW = $clog2(PW);

    sel_e sel;
    logic is_cfg;

    assign sel    = sel_e'(addr);
    assign is_cfg = din[PW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
            dir   <= DIR_ALL_IN;
            cword <= '0;
        end else if (commit) begin
            unique case (sel)
                SEL_PA: lat_a <= din;
                SEL_PB: lat_b <= din;
                SEL_PC: lat_c <= din;
                SEL_CW: begin
                    if (is_cfg) begin
                        cword     <= din;
                        dir.a_in  <= din[4];
                        dir.cu_in <= din[3];
                        dir.b_in  <= din[1];
                        dir.cl_in <= din[0];
                        lat_a     <= '0;
                        lat_b     <= '0;
                        lat_c     <= '0;
                    end else begin
                        lat_c[din[IW:1]] <= din[0];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ppi_rdmux.sv
module ppi_rdmux
    import ppi_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  dir_t          dir,
    input  logic [PW-1:0] lat_a,
    input  logic [PW-1:0] lat_b,
    input  logic [PW-1:0] lat_c,
    input  logic [PW-1:0] cword,
    input  logic [PW-1:0] pa_in,
    input  logic [PW-1:0] pb_in,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] dout,
    output logic          dout_en
);
    localparam int HW = PW / 2;

    logic [PW-1:0] view_c;

    assign view_c[PW-1:HW] = dir.cu_in ? pc_in[PW-1:HW] : lat_c[PW-1:HW];
    assign view_c[HW-1:0]  = dir.cl_in ? pc_in[HW-1:0]  : lat_c[HW-1:0];

    assign dout_en = !cs_n && !rd_n && wr_n;

    always_comb begin
        unique case (sel_e'(addr))
            SEL_PA:  dout = dir.a_in ? pa_in : lat_a;
            SEL_PB:  dout = dir.b_in ? pb_in : lat_b;
            SEL_PC:  dout = view_c;
            SEL_CW:  dout = cword;
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/ppi_unit.sv
module ppi_unit
    import ppi_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic [1:0]    addr,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout,
    output logic          dout_en,
    input  logic [PW-1:0] pa_in,
    output logic [PW-1:0] pa_out,
    output logic [PW-1:0] pa_oe,
    input  logic [PW-1:0] pb_in,
    output logic [PW-1:0] pb_out,
    output logic [PW-1:0] pb_oe,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] pc_out,
    output logic [PW-1:0] pc_oe
);
    localparam int HW = PW / 2;

    logic          commit;
    dir_t          dir;
    logic [PW-1:0] lat_a, lat_b, lat_c, cword;

    ppi_bus_fsm u_fsm (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .commit(commit)
    );

    ppi_regs #(.PW(PW)) u_regs (
        .clk(clk), .rst(rst), .commit(commit), .addr(addr), .din(din),
        .lat_a(lat_a), .lat_b(lat_b), .lat_c(lat_c), .dir(dir), .cword(cword)
    );

    ppi_rdmux #(.PW(PW)) u_rd (
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .dir(dir),
        .lat_a(lat_a), .lat_b(lat_b), .lat_c(lat_c), .cword(cword),
        .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
        .dout(dout), .dout_en(dout_en)
    );

    assign pa_out = lat_a;
    assign pb_out = lat_b;
    assign pc_out = lat_c;
    assign pa_oe  = {PW{~dir.a_in}};
    assign pb_oe  = {PW{~dir.b_in}};

    for (genvar h = 0; h < 2; h++) begin : g_pc_half
        logic half_in;
        assign half_in = (h == 0) ? dir.cl_in : dir.cu_in;
        assign pc_oe[h*HW +: HW] = {HW{~half_in}};
    end
endmodule

// File: rtl/ppi_unit_chk.sv
module ppi_unit_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic [1:0]    addr,
    input logic          wr_n,
    input logic [PW-1:0] din,
    input logic [PW-1:0] pa_out,
    input logic [PW-1:0] pb_out,
    input logic [PW-1:0] pc_out,
    input logic [PW-1:0] pa_oe,
    input logic [PW-1:0] pb_oe,
    input logic [PW-1:0] pc_oe
);
    localparam int HW = PW / 2;

    logic rst_seen = 1'b0;
    logic unused_din;
    assign unused_din = ^{din[6:5], din[2]};

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: the cycle after a reset cycle shows every port as input with cleared latches
    always_ff @(negedge clk) begin
        if (rst_seen) begin
            p_reset_state_r1: assert (pa_oe == '0 && pb_oe == '0 && pc_oe == '0
                                      && pa_out == '0 && pb_out == '0 && pc_out == '0)
                else $error("reset state wrong");
        end
    end

    // R2
    p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out)
                 && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

    // R4
    p_cfg_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && $past(wr_n) && addr == 2'b11 && din[7])
        |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

    // R3
    p_cfg_dirs_r3: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && $past(wr_n) && addr == 2'b11 && din[7])
        |=> (pa_oe[0] == !$past(din[4]) && pc_oe[PW-1] == !$past(din[3])
             && pb_oe[0] == !$past(din[1]) && pc_oe[0] == !$past(din[0])
             && pc_oe[HW-1] == pc_oe[0] && pc_oe[HW] == pc_oe[PW-1]));

    // R5
    p_bitcmd_keeps_dirs_r5: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && addr == 2'b11 && !din[7])
        |=> $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)
            && $stable(pa_out) && $stable(pb_out));

    // R7
    p_single_commit_r7: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && !$past(cs_n) && !$past(wr_n) && !$past(rst))
        |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out)
            && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));
endmodule

bind ppi_unit ppi_unit_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .wr_n(wr_n), .din(din),
    .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
    .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe)
);

// File: tb/sim_ppi_unit.sv
module sim_ppi_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_en;
    logic [7:0] pa_in = 8'h3C, pb_in = 8'hC3, pc_in = 8'hF0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_a = 8'h00, m_b = 8'h00, m_c = 8'h00, m_cw = 8'h00;
    bit m_ain = 1, m_bin = 1, m_cuin = 1, m_clin = 1;
    bit m_busy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppi_unit u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .din(din), .dout(dout), .dout_en(dout_en),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_a = 0; m_b = 0; m_c = 0; m_cw = 0;
            m_ain = 1; m_bin = 1; m_cuin = 1; m_clin = 1; m_busy = 0;
        end else begin
            if (!cs_n && !wr_n && !m_busy) begin
                if (addr == 0) m_a = din;
                else if (addr == 1) m_b = din;
                else if (addr == 2) m_c = din;
                else if (din[7]) begin
                    m_cw = din; m_ain = din[4]; m_cuin = din[3];
                    m_bin = din[1]; m_clin = din[0];
                    m_a = 0; m_b = 0; m_c = 0;
                end else begin
                    m_c[int'(din[3:1])] = din[0];
                end
            end
            m_busy = !cs_n && !wr_n;
        end
    end

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        logic [7:0] c;
        c[7:4] = m_cuin ? pc_in[7:4] : m_c[7:4];
        c[3:0] = m_clin ? pc_in[3:0] : m_c[3:0];
        case (a)
            2'd0: return m_ain ? pa_in : m_a;
            2'd1: return m_bin ? pb_in : m_b;
            2'd2: return c;
            default: return m_cw;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4 pa_out", pa_out, m_a);
            chk("R4 pb_out", pb_out, m_b);
            chk("R5 pc_out", pc_out, m_c);
            chk("R3 pa_oe", pa_oe, {8{!m_ain}});
            chk("R3 pb_oe", pb_oe, {8{!m_bin}});
            chk("R3 pc_oe", pc_oe, {{4{!m_cuin}}, {4{!m_clin}}});
            chk("R9 dout_en", {7'd0, dout_en}, {7'd0, !cs_n && !rd_n && wr_n});
            if (dout_en) chk("R6 dout", dout, exp_read(addr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cs_n = 0; addr = a; din = d; wr_n = 0;
        @(posedge clk); #1;
        wr_n = 1; cs_n = 1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        cs_n = 0; addr = a; rd_n = 0;
        #1 d = dout;
        @(posedge clk); #1;
        rd_n = 1; cs_n = 1;
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        chk("R1 oe in reset", pa_oe | pb_oe | pc_oe, 8'h00);
        #1 rst = 0;
        rd(2'd3, r);           chk("R1 cword after reset", r, 8'h00);
        chk("R1 all inputs", pa_oe | pb_oe | pc_oe, 8'h00);

        wr(2'd0, 8'h5A);
        rd(2'd0, r);           chk("R6 input A reads pins", r, 8'h3C);

        wr(2'd3, 8'h80);
        chk("R4 latch A cleared", pa_out, 8'h00);
        chk("R3 all outputs", pa_oe & pb_oe & pc_oe, 8'hFF);
        rd(2'd3, r);           chk("R4 cword readback", r, 8'h80);

        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'h96);
        chk("R2 only B changed by B write", pa_out, 8'hA5);
        rd(2'd0, r);           chk("R6 output A reads latch", r, 8'hA5);
        rd(2'd2, r);           chk("R6 output C reads latch", r, 8'h96);

        wr(2'd3, 8'h07);       chk("R5 set bit 3", pc_out, 8'h9E);
        wr(2'd3, 8'h0E);       chk("R5 clear bit 7", pc_out, 8'h1E);
        rd(2'd3, r);           chk("R5 cword unchanged", r, 8'h80);
        chk("R5 dirs unchanged", pc_oe, 8'hFF);

        wr(2'd3, 8'h88);
        chk("R3 C split oe", pc_oe, 8'h0F);
        wr(2'd2, 8'h5A);
        rd(2'd2, r);           chk("R6 C split read", r, 8'hFA);

        wr(2'd3, 8'hF6);
        chk("R8 A input", pa_oe, 8'h00);
        chk("R8 B input", pb_oe, 8'h00);
        chk("R8 C output", pc_oe, 8'hFF);

        // writes with chip select high
        wr(2'd2, 8'h44);
        @(posedge clk); #1;
        addr = 2'd2; din = 8'h77; wr_n = 0;
        @(posedge clk); #1;
        addr = 2'd3; din = 8'h80;
        @(posedge clk); #1;
        wr_n = 1;
        chk("R2 deselected write ignored", pc_out, 8'h44);
        chk("R2 deselected cfg ignored", pc_oe, 8'hFF);
        rd_n = 0; #1;
        chk("R9 no read when deselected", {7'd0, dout_en}, 8'h00);
        rd_n = 1;

        // held strobe with changing data
        @(posedge clk); #1;
        cs_n = 0; addr = 2'd2; din = 8'h11; wr_n = 0;
        @(posedge clk); #1;
        din = 8'h22;
        repeat (3) @(posedge clk); #1;
        wr_n = 1; cs_n = 1;
        chk("R7 one commit per strobe", pc_out, 8'h11);

        // read and write together
        @(posedge clk); #1;
        cs_n = 0; addr = 2'd3; rd_n = 0; wr_n = 0; din = 8'h0F;
        #1 chk("R9 no read during write", {7'd0, dout_en}, 8'h00);
        @(posedge clk); #1;
        rd_n = 1; wr_n = 1; cs_n = 1;
        chk("R5 bit command during read", pc_out, 8'h91);

        repeat (2) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule